// File: doc/BRIEF.md
# Variable-Length Instruction Fetch Decoder

This block walks a byte-coded instruction stream whose instructions take one, two, five or six bytes. It owns the program counter and presents it on `fetch_pc`. The instruction memory answers with a window of bytes starting at that address, with the byte at `fetch_pc` in bits [7:0] and each following byte in the next eight bits. The block breaks the leading byte into a 4-bit operation class and a 4-bit variant. It picks out the two register selectors and the little-endian 32-bit constant where the class has them. It works out the instruction length and the following PC, and hands the result downstream as one registered record.

Both edges of the block are valid/ready streams. A window is taken only on a cycle where `win_valid` and `win_ready` are both high. The block raises `win_ready` only when it has not stopped and its output register is empty or is being drained in that same cycle. Once `out_valid` is high, the record holds every field until `out_ready` takes it. A downstream stall therefore stalls fetch, and no window is dropped.

A call sends the PC to its destination. Every other valid instruction steps the PC by its own length. After a halt or an unrecognised encoding has been reported, the block stops accepting windows until reset. `halted` and `fault` show which of the two caused the stop.

Top module: `vfd_fetch_decode`

## Requirements
- R1: While reset is held and directly after it is released, `out_valid`, `halted` and `fault` are 0, `fetch_pc` equals RESET_PC (0 by default) and `win_ready` is 1.
- R2: `out_icode` reports bits [7:4] of the first window byte and `out_ifun` reports bits [3:0] of that byte.
- R3: `out_len` is 1 for class 0 (halt) and class 1 (nop), 2 for class 6 (ALU op), 5 for class 8 (call), 6 for classes 3, 4 and 5 (immediate move, store, load), and 0 for an invalid encoding.
- R4: For classes 3, 4, 5 and 6, `out_ra` is bits [7:4] and `out_rb` is bits [3:0] of the second byte. A selector value of 4'hF sets the matching `*_none` flag. Classes 0, 1 and 8 report both selectors as 4'hF, with both flags set.
- R5: `out_imm` holds bytes 1..4 for class 8 and bytes 2..5 for classes 3, 4 and 5, with the lowest-addressed byte as the least significant. It is 0 for all other classes.
- R6: `out_next_pc` is the destination constant for a call and `out_pc + out_len` for any other valid instruction. When the record appears, `fetch_pc` already equals `out_next_pc`.
- R7: An encoding is invalid when its class is 2, 7 or 9..15, when class 6 has a variant above 3, or when any other class has a nonzero variant. An invalid encoding yields one record with `out_invalid`=1 and `out_next_pc`=`out_pc`, and sets `fault`. `fetch_pc` does not move, and no further record appears until reset.
- R8: A halt yields one record, sets `halted`, and leaves `fetch_pc` at the halt address plus 1. No further record appears until reset, even with `win_valid` held high.
- R9: While `out_valid` is 1 and `out_ready` is 0, the record stays unchanged, `win_ready` is 0 and `fetch_pc` holds.
- R10: With `win_valid` low, no window is taken, `fetch_pc` holds, and `out_valid` falls once the pending record has been taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| fetch_pc | output | ADDR_W | Address of the window wanted next |
| win_valid | input | 1 | Window bytes for `fetch_pc` are present |
| win_ready | output | 1 | Block takes the window this cycle |
| win_data | input | 8*(IMM_BYTES+2) | Window, byte k at bits [8k+7:8k] |
| out_valid | output | 1 | Decoded record present |
| out_ready | input | 1 | Downstream takes the record |
| out_pc | output | ADDR_W | Address of the decoded instruction |
| out_icode | output | 4 | Operation class |
| out_ifun | output | 4 | Variant within the class |
| out_ra | output | 4 | First register selector |
| out_rb | output | 4 | Second register selector |
| out_ra_none | output | 1 | First selector is "no register" |
| out_rb_none | output | 1 | Second selector is "no register" |
| out_imm | output | 8*IMM_BYTES | Constant, offset or call destination |
| out_len | output | 4 | Instruction length in bytes |
| out_next_pc | output | ADDR_W | Address of the next instruction |
| out_invalid | output | 1 | Encoding not recognised |
| halted | output | 1 | Halt has been decoded |
| fault | output | 1 | Invalid encoding has been decoded |

## Verification
A window taken at a rising edge shows up as a record one edge later. At that same edge `fetch_pc` moves to the next address, so the bench samples the record and `fetch_pc` together at the falling edge after the edge that took the window. With `out_ready` high, records come out on back-to-back falling edges, one per instruction. The bench collects each one at its own falling edge and does not skip a cycle. The stall, idle and stop checks sample on each falling edge across several cycles, confirming that nothing changes and no record appears during that stretch.

// File: rtl/vfd_pkg.sv
`timescale 1ns/1ps
package vfd_pkg;
  localparam int LEN_W = 4;

  localparam logic [3:0] IC_HALT  = 4'h0;
  localparam logic [3:0] IC_NOP   = 4'h1;
  localparam logic [3:0] IC_IRMOV = 4'h3;
  localparam logic [3:0] IC_RMMOV = 4'h4;
  localparam logic [3:0] IC_MRMOV = 4'h5;
  localparam logic [3:0] IC_ALU   = 4'h6;
  localparam logic [3:0] IC_CALL  = 4'h8;

  localparam logic [3:0] ALU_FN_LAST = 4'h3;
  localparam logic [3:0] REG_NONE    = 4'hF;

  typedef enum logic [1:0] {
    IMM_NONE = 2'd0,
    IMM_AT1  = 2'd1,
    IMM_AT2  = 2'd2
  } imm_pos_e;

  typedef struct packed {
    logic             ok;
    logic [LEN_W-1:0] len;
    logic             has_regs;
    imm_pos_e         ipos;
    logic             is_halt;
    logic             is_call;
  } cls_t;
endpackage

// File: rtl/vfd_class_decode.sv
`timescale 1ns/1ps
module vfd_class_decode
  import vfd_pkg::*;
#(
  parameter int IMM_BYTES = 4
) (
  input  logic [7:0] op_byte,
  output cls_t       cls
);
  localparam logic [LEN_W-1:0] LEN_SHORT = LEN_W'(1);
  localparam logic [LEN_W-1:0] LEN_REGS  = LEN_W'(2);
  localparam logic [LEN_W-1:0] LEN_CALL  = LEN_W'(1 + IMM_BYTES);
  localparam logic [LEN_W-1:0] LEN_LONG  = LEN_W'(2 + IMM_BYTES);

  logic [3:0] icode;
  logic [3:0] ifun;
  logic       fun_zero;

  assign icode    = op_byte[7:4];
  assign ifun     = op_byte[3:0];
  assign fun_zero = (ifun == 4'h0);

  always_comb begin
    cls          = '0;
    cls.ipos     = IMM_NONE;
    unique case (icode)
      IC_HALT: begin
        cls.ok      = fun_zero;
        cls.len     = LEN_SHORT;
        cls.is_halt = 1'b1;
      end
      IC_NOP: begin
        cls.ok  = fun_zero;
        cls.len = LEN_SHORT;
      end
      IC_ALU: begin
        cls.ok       = (ifun <= ALU_FN_LAST);
        cls.len      = LEN_REGS;
        cls.has_regs = 1'b1;
      end
      IC_IRMOV, IC_RMMOV, IC_MRMOV: begin
        cls.ok       = fun_zero;
        cls.len      = LEN_LONG;
        cls.has_regs = 1'b1;
        cls.ipos     = IMM_AT2;
      end
      IC_CALL: begin
        cls.ok      = fun_zero;
        cls.len     = LEN_CALL;
        cls.ipos    = IMM_AT1;
        cls.is_call = 1'b1;
      end
      default: cls.ok = 1'b0;
    endcase
    if (!cls.ok) begin
      cls.len     = '0;
      cls.is_halt = 1'b0;
      cls.is_call = 1'b0;
    end
  end
endmodule

// File: rtl/vfd_field_extract.sv
`timescale 1ns/1ps
module vfd_field_extract
  import vfd_pkg::*;
#(
  parameter int IMM_BYTES = 4
) (
  input  logic [8*(IMM_BYTES+1)-1:0] tail,
  input  logic                       has_regs,
  input  imm_pos_e                   ipos,
  output logic [3:0]                 ra,
  output logic [3:0]                 rb,
  output logic                       ra_none,
  output logic                       rb_none,
  output logic [8*IMM_BYTES-1:0]     imm
);
  localparam int IMM_W = 8 * IMM_BYTES;

  logic [IMM_W-1:0] imm_at1;
  logic [IMM_W-1:0] imm_at2;

  // tail byte j is window byte j+1; constants are lowest byte first
  for (genvar b = 0; b < IMM_BYTES; b++) begin : g_gather
    assign imm_at1[8*b +: 8] = tail[8*b +: 8];
    assign imm_at2[8*b +: 8] = tail[8*(b+1) +: 8];
  end

  assign ra      = has_regs ? tail[7:4] : REG_NONE;
  assign rb      = has_regs ? tail[3:0] : REG_NONE;
  assign ra_none = (ra == REG_NONE);
  assign rb_none = (rb == REG_NONE);

  always_comb begin
    unique case (ipos)
      IMM_AT1: imm = imm_at1;
      IMM_AT2: imm = imm_at2;
      default: imm = '0;
    endcase
  end
endmodule

// File: rtl/vfd_next_pc.sv
`timescale 1ns/1ps
module vfd_next_pc
  import vfd_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int IMM_BYTES = 4
) (
  input  logic [ADDR_W-1:0]      pc,
  input  logic [LEN_W-1:0]       len,
  input  logic                   ok,
  input  logic                   is_call,
  input  logic [8*IMM_BYTES-1:0] dest,
  output logic [ADDR_W-1:0]      npc
);
  logic [ADDR_W-1:0] seq_pc;

  assign seq_pc = pc + ADDR_W'(len);

  always_comb begin
    if (!ok)          npc = pc;
    else if (is_call) npc = ADDR_W'(dest);
    else              npc = seq_pc;
  end
endmodule

// File: rtl/vfd_fetch_decode.sv
`timescale 1ns/1ps
module vfd_fetch_decode
  import vfd_pkg::*;
#(
  parameter int                ADDR_W    = 32,
  parameter int                IMM_BYTES = 4,
  parameter logic [ADDR_W-1:0] RESET_PC  = '0
) (
  input  logic                         clk,
  input  logic                         rst_n,
  output logic [ADDR_W-1:0]            fetch_pc,
  input  logic                         win_valid,
  output logic                         win_ready,
  input  logic [8*(IMM_BYTES+2)-1:0]   win_data,
  output logic                         out_valid,
  input  logic                         out_ready,
  output logic [ADDR_W-1:0]            out_pc,
  output logic [3:0]                   out_icode,
  output logic [3:0]                   out_ifun,
  output logic [3:0]                   out_ra,
  output logic [3:0]                   out_rb,
  output logic                         out_ra_none,
  output logic                         out_rb_none,
  output logic [8*IMM_BYTES-1:0]       out_imm,
  output logic [3:0]                   out_len,
  output logic [ADDR_W-1:0]            out_next_pc,
  output logic                         out_invalid,
  output logic                         halted,
  output logic                         fault
);
  localparam int WIN_W = 8 * (IMM_BYTES + 2);
  localparam int IMM_W = 8 * IMM_BYTES;

  cls_t              cls;
  logic [3:0]        ra_c, rb_c;
  logic              ra_none_c, rb_none_c;
  logic [IMM_W-1:0]  imm_c;
  logic [ADDR_W-1:0] npc_c;
  logic [ADDR_W-1:0] pc_q;
  logic              halted_q, fault_q, oval_q;
  logic              take;

  vfd_class_decode #(.IMM_BYTES(IMM_BYTES)) u_cls (
    .op_byte (win_data[7:0]),
    .cls     (cls)
  );

  vfd_field_extract #(.IMM_BYTES(IMM_BYTES)) u_fld (
    .tail     (win_data[WIN_W-1:8]),
    .has_regs (cls.has_regs),
    .ipos     (cls.ipos),
    .ra       (ra_c),
    .rb       (rb_c),
    .ra_none  (ra_none_c),
    .rb_none  (rb_none_c),
    .imm      (imm_c)
  );

  vfd_next_pc #(.ADDR_W(ADDR_W), .IMM_BYTES(IMM_BYTES)) u_npc (
    .pc      (pc_q),
    .len     (cls.len),
    .ok      (cls.ok),
    .is_call (cls.is_call),
    .dest    (imm_c),
    .npc     (npc_c)
  );

  assign win_ready = !(halted_q || fault_q) && (!oval_q || out_ready);
  assign take      = win_valid && win_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q        <= RESET_PC;
      oval_q      <= 1'b0;
      halted_q    <= 1'b0;
      fault_q     <= 1'b0;
      out_pc      <= '0;
      out_icode   <= '0;
      out_ifun    <= '0;
      out_ra      <= REG_NONE;
      out_rb      <= REG_NONE;
      out_ra_none <= 1'b1;
      out_rb_none <= 1'b1;
      out_imm     <= '0;
      out_len     <= '0;
      out_next_pc <= '0;
      out_invalid <= 1'b0;
    end else if (take) begin
      pc_q        <= npc_c;
      oval_q      <= 1'b1;
      out_pc      <= pc_q;
      out_icode   <= win_data[7:4];
      out_ifun    <= win_data[3:0];
      out_ra      <= ra_c;
      out_rb      <= rb_c;
      out_ra_none <= ra_none_c;
      out_rb_none <= rb_none_c;
      out_imm     <= imm_c;
      out_len     <= cls.len;
      out_next_pc <= npc_c;
      out_invalid <= !cls.ok;
      if (cls.is_halt) halted_q <= 1'b1;
      if (!cls.ok)     fault_q  <= 1'b1;
    end else if (out_ready) begin
      oval_q <= 1'b0;
    end
  end

  assign fetch_pc  = pc_q;
  assign out_valid = oval_q;
  assign halted    = halted_q;
  assign fault     = fault_q;

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_pc) && $stable(out_imm)
                                   && $stable(out_icode) && $stable(out_next_pc))); // R9

  AST_IDLE_PC_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    !(win_valid && win_ready) |=> $stable(fetch_pc)); // R10

  AST_LEN_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_invalid) |-> (out_len == 4'd1 || out_len == 4'd2
                                     || out_len == 4'(1 + IMM_BYTES)
                                     || out_len == 4'(2 + IMM_BYTES))); // R3

  AST_SEQ_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_invalid && out_icode != IC_CALL)
      |-> (out_next_pc == out_pc + ADDR_W'(out_len))); // R6

  AST_BAD_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_invalid) |-> (fetch_pc == out_pc && fault)); // R7

  AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> ($stable(fetch_pc) && $stable(halted))); // R8

  AST_NONE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_ra_none == (out_ra == REG_NONE))); // R4
endmodule

// File: tb/vfd_fetch_decode_test.sv
`timescale 1ns/1ps
module vfd_fetch_decode_test;
  localparam int ADDR_W = 32;
  localparam int IMM_BYTES = 4;
  localparam int WB = IMM_BYTES + 2;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic [ADDR_W-1:0]   fetch_pc;
  logic                win_valid = 1'b0;
  logic                win_ready;
  logic [8*WB-1:0]     win_data;
  logic                out_valid;
  logic                out_ready = 1'b1;
  logic [ADDR_W-1:0]   out_pc;
  logic [3:0]          out_icode, out_ifun, out_ra, out_rb, out_len;
  logic                out_ra_none, out_rb_none, out_invalid, halted, fault;
  logic [8*IMM_BYTES-1:0] out_imm;
  logic [ADDR_W-1:0]   out_next_pc;

  logic [7:0] mem [0:255];
  int nchk = 0;
  int nbad = 0;
  bit done = 0;

  always #4 clk = ~clk; // 8 ns period, 125 MHz

  always_comb begin
    for (int i = 0; i < WB; i++) win_data[8*i +: 8] = mem[fetch_pc[7:0] + 8'(i)];
  end

  vfd_fetch_decode #(.ADDR_W(ADDR_W), .IMM_BYTES(IMM_BYTES)) uut (
    .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc), .win_valid(win_valid),
    .win_ready(win_ready), .win_data(win_data), .out_valid(out_valid),
    .out_ready(out_ready), .out_pc(out_pc), .out_icode(out_icode),
    .out_ifun(out_ifun), .out_ra(out_ra), .out_rb(out_rb),
    .out_ra_none(out_ra_none), .out_rb_none(out_rb_none), .out_imm(out_imm),
    .out_len(out_len), .out_next_pc(out_next_pc), .out_invalid(out_invalid),
    .halted(halted), .fault(fault)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic fill_mem();
    for (int i = 0; i < 256; i++) mem[i] = 8'h10;
  endtask

  // reset, then R1 checks before the first active edge
  task automatic do_reset();
    rst_n = 1'b0; win_valid = 1'b0; out_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R1 out_valid", 64'(out_valid), 64'd0);
    chk("R1 fetch_pc", 64'(fetch_pc), 64'd0);
    chk("R1 halted", 64'(halted), 64'd0);
    chk("R1 fault", 64'(fault), 64'd0);
    chk("R1 win_ready", 64'(win_ready), 64'd1);
  endtask

  task automatic wait_rec(input string tag, output bit got);
    got = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (out_valid) begin got = 1; break; end
    end
    if (!got) begin
      nchk++; nbad++;
      $display("FAIL %s actual=no record expected=record", tag);
    end
  endtask

  task automatic expect_rec(input logic [31:0] pc, input logic [3:0] ic, input logic [3:0] fn,
                            input logic [3:0] ra, input logic [3:0] rb,
                            input logic [31:0] imm, input logic [3:0] len,
                            input logic [31:0] npc);
    bit got;
    wait_rec("R6 record present", got);
    if (!got) return;
    chk("R6 out_pc", 64'(out_pc), 64'(pc));
    chk("R2 icode", 64'(out_icode), 64'(ic));
    chk("R2 ifun", 64'(out_ifun), 64'(fn));
    chk("R4 ra", 64'(out_ra), 64'(ra));
    chk("R4 rb", 64'(out_rb), 64'(rb));
    chk("R4 ra_none", 64'(out_ra_none), 64'(ra == 4'hF));
    chk("R4 rb_none", 64'(out_rb_none), 64'(rb == 4'hF));
    chk("R5 imm", 64'(out_imm), 64'(imm));
    chk("R3 len", 64'(out_len), 64'(len));
    chk("R6 next_pc", 64'(out_next_pc), 64'(npc));
    chk("R6 fetch_pc follows", 64'(fetch_pc), 64'(npc));
    chk("R7 invalid clear", 64'(out_invalid), 64'd0);
  endtask

  task automatic put(input int a, input logic [7:0] b);
    mem[a] = b;
  endtask

  task automatic test_stream();
    fill_mem();
    put(0, 8'h10);
    put(1, 8'h60); put(2, 8'h12);
    put(3, 8'h63); put(4, 8'h7F);
    put(5, 8'h30); put(6, 8'hF3); put(7, 8'h00); put(8, 8'h01); put(9, 8'h00); put(10, 8'h00);
    put(11, 8'h40); put(12, 8'h12); put(13, 8'h78); put(14, 8'h56); put(15, 8'h34); put(16, 8'h12);
    put(17, 8'h50); put(18, 8'hAB); put(19, 8'hFC); put(20, 8'hFF); put(21, 8'hFF); put(22, 8'hFF);
    put(23, 8'h80); put(24, 8'h40); put(25, 8'h00); put(26, 8'h00); put(27, 8'h00);
    put(64, 8'h00);
    do_reset();
    win_valid = 1'b1;
    expect_rec(0,  4'h1, 4'h0, 4'hF, 4'hF, 0, 1, 1);                     // R3 nop
    expect_rec(1,  4'h6, 4'h0, 4'h1, 4'h2, 0, 2, 3);                     // R4 alu
    expect_rec(3,  4'h6, 4'h3, 4'h7, 4'hF, 0, 2, 5);                     // R4 none
    expect_rec(5,  4'h3, 4'h0, 4'hF, 4'h3, 32'h100, 6, 11);              // R5 256
    expect_rec(11, 4'h4, 4'h0, 4'h1, 4'h2, 32'h12345678, 6, 17);         // R5 store
    expect_rec(17, 4'h5, 4'h0, 4'hA, 4'hB, 32'hFFFFFFFC, 6, 23);         // R5 load
    expect_rec(23, 4'h8, 4'h0, 4'hF, 4'hF, 32'h40, 5, 32'h40);           // R6 call
    expect_rec(64, 4'h0, 4'h0, 4'hF, 4'hF, 0, 1, 65);                    // R8 halt
    chk("R8 halted", 64'(halted), 64'd1);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk("R8 no record after halt", 64'(out_valid), 64'd0);
      chk("R8 fetch_pc frozen", 64'(fetch_pc), 64'd65);
    end
    chk("R8 win_ready low", 64'(win_ready), 64'd0);
    win_valid = 1'b0;
  endtask

  task automatic test_stall();
    fill_mem();
    put(1, 8'h60); put(2, 8'h12);
    do_reset();
    out_ready = 1'b0;
    win_valid = 1'b1;
    @(negedge clk);
    for (int k = 0; k < 3; k++) begin
      chk("R9 held valid", 64'(out_valid), 64'd1);
      chk("R9 held pc", 64'(out_pc), 64'd0);
      chk("R9 win_ready low", 64'(win_ready), 64'd0);
      chk("R9 fetch_pc holds", 64'(fetch_pc), 64'd1);
      @(negedge clk);
    end
    out_ready = 1'b1;
    expect_rec(1, 4'h6, 4'h0, 4'h1, 4'h2, 0, 2, 3);                      // R9 resume
    win_valid = 1'b0;
  endtask

  task automatic test_idle();
    fill_mem();
    do_reset();
    win_valid = 1'b1;
    @(negedge clk);
    win_valid = 1'b0;
    chk("R10 first record", 64'(out_valid), 64'd1);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R10 out_valid drops", 64'(out_valid), 64'd0);
      chk("R10 fetch_pc holds", 64'(fetch_pc), 64'd1);
    end
  endtask

  task automatic test_bad(input logic [7:0] op, input string tag);
    bit got;
    fill_mem();
    put(1, op);
    do_reset();
    win_valid = 1'b1;
    expect_rec(0, 4'h1, 4'h0, 4'hF, 4'hF, 0, 1, 1);
    wait_rec(tag, got);
    if (got) begin
      chk({tag, " R7 invalid"}, 64'(out_invalid), 64'd1);
      chk({tag, " R7 next_pc"}, 64'(out_next_pc), 64'd1);
      chk({tag, " R3 len zero"}, 64'(out_len), 64'd0);
      chk({tag, " R7 fault"}, 64'(fault), 64'd1);
      chk({tag, " R7 fetch_pc"}, 64'(fetch_pc), 64'd1);
    end
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk({tag, " R7 no more records"}, 64'(out_valid), 64'd0);
    end
    win_valid = 1'b0;
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      nchk++; nbad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  end

  initial begin
    test_stream();
    test_stall();
    test_idle();
    test_bad(8'h20, "class 2");
    test_bad(8'h64, "alu variant 4");
    test_bad(8'h11, "nop variant 1");
    test_bad(8'hC0, "class 12");
    done = 1;
    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule